// File: doc/BRIEF.md
# Eight-Bit ALU with Condition Flags

This combinational unit does the arithmetic, logic, rotate and shift work of a small 8-bit processor. It takes two operands and a 3-bit operation code, and returns an 8-bit result together with the Carry, Zero, Sign and Overflow condition bits. Each condition bit comes with its own write enable, so the register file can keep the bits an operation leaves untouched.

Compare and bit-test need no operation code of their own. The caller issues subtract or AND and discards the result. Subtraction adds the inverted second operand plus one, so a set Carry means that no borrow occurred.

The condition bits and their enables are both delivered as bytes laid out like the processor's flag register. That lets the caller merge them into the stored flags with a bytewise select.

Top module: `alu8`

## Requirements
- R1: Operation code 0 (add) gives res_o = (a_i + b_i) mod 256, and Carry equals bit 8 of the 9-bit sum.
- R2: Operation code 1 (subtract) gives res_o = (a_i + ~b_i + 1) mod 256, and Carry is 1 exactly when a_i >= b_i as unsigned numbers.
- R3: For add and subtract, Overflow is 1 exactly when the true signed result of the two operands, read as two's complement, lies outside -128..127.
- R4: For every operation, Zero is 1 exactly when res_o is 0, and Sign equals res_o[7].
- R5: Operation codes 2, 3 and 4 give a_i AND b_i, a_i OR b_i and a_i XOR b_i.
- R6: Operation code 5 rotates a_i right by b_i[2:0] places. A rotate amount of 0 returns a_i unchanged, and b_i[7:3] has no effect on the result.
- R7: Operation code 6 shifts a_i left by one and fills bit 0 with 0. Carry is the old a_i[7], Overflow is a_i[7] XOR a_i[6], and b_i has no effect.
- R8: Operation code 7 shifts a_i right by one and fills bit 7 with 0. Carry is the old a_i[0], Overflow is the old a_i[7], and b_i has no effect.
- R9: In both flg_o and flg_we_o, Carry sits at bit 7, Zero at bit 6, Sign at bit 5 and Overflow at bit 4. Bits 3:0 are always 0, and a flag whose enable is 0 reads as 0 in flg_o.
- R10: Operation codes 0, 1, 6 and 7 enable all four flags (flg_we_o = 8'hF0). Operation codes 2 through 5 enable only Zero and Sign (flg_we_o = 8'h60).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand; the value that is rotated or shifted |
| b_i | input | 8 | Second operand; low 3 bits give the rotate amount |
| op_i | input | 3 | Operation code 0..7 |
| res_o | output | 8 | Operation result |
| flg_o | output | 8 | Condition bits in flag-register layout |
| flg_we_o | output | 8 | Per-flag write enables, same layout as flg_o |

## Verification
The unit holds no state, so any fault shows at the ports as soon as the inputs settle, in the same cycle those inputs are applied. The expected effects of a fault are these:

- A wrong carry-in on subtract moves res_o by one and breaks the a >= b Carry rule.
- A swapped overflow term shows up only on operand pairs whose signs are chosen to provoke it.
- A stray enable changes flg_we_o at once.

The bench therefore drives every operation code over a grid of boundary operands (0, 1, 0x7F, 0x80, 0xFF and others). It compares every output field against a reference model in each cycle.

// File: rtl/alu8.sv
module alu8 (
  input  logic [7:0] a_i,
  input  logic [7:0] b_i,
  input  logic [2:0] op_i,
  output logic [7:0] res_o,
  output logic [7:0] flg_o,
  output logic [7:0] flg_we_o
);
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_OR  = 3'd3,
                         OP_XOR = 3'd4, OP_ROR = 3'd5, OP_SHL = 3'd6, OP_SHR = 3'd7;

  logic        sub;
  logic [7:0]  addend;
  logic [8:0]  sum;
  logic [15:0] rot;
  logic        cy, ov, arith;

  assign sub    = (op_i == OP_SUB);
  assign addend = sub ? ~b_i : b_i;
  assign sum    = {1'b0, a_i} + {1'b0, addend} + {8'd0, sub};
  assign rot    = {a_i, a_i} >> b_i[2:0];
  assign arith  = (op_i == OP_ADD) || sub || (op_i == OP_SHL) || (op_i == OP_SHR);

  always_comb begin
    res_o = sum[7:0];
    cy    = sum[8];
    ov    = (a_i[7] == addend[7]) && (sum[7] != a_i[7]);
    case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_ROR: res_o = rot[7:0];
      OP_SHL: begin
        res_o = {a_i[6:0], 1'b0};
        cy    = a_i[7];
        ov    = a_i[7] ^ a_i[6];
      end
      OP_SHR: begin
        res_o = {1'b0, a_i[7:1]};
        cy    = a_i[0];
        ov    = a_i[7];
      end
      default: ;
    endcase
  end

  assign flg_we_o = {arith, 1'b1, 1'b1, arith, 4'b0000};
  assign flg_o    = {cy & arith, (res_o == 8'd0), res_o[7], ov & arith, 4'b0000};
endmodule

module alu8_chk (
  input logic [7:0] a_i,
  input logic [7:0] b_i,
  input logic [2:0] op_i,
  input logic [7:0] res_o,
  input logic [7:0] flg_o,
  input logic [7:0] flg_we_o
);
  always_comb begin
    assert_zero_flag_R4: assert (flg_o[6] == (res_o == 8'd0));
    assert_sign_flag_R4: assert (flg_o[5] == res_o[7]);
    assert_low_bits_R9:  assert (flg_o[3:0] == 4'd0 && flg_we_o[3:0] == 4'd0);
    if (op_i == 3'd1)
      assert_sub_carry_R2: assert (flg_o[7] == (a_i >= b_i));
    if (op_i >= 3'd2 && op_i <= 3'd5)
      assert_zs_only_R10: assert (flg_we_o == 8'h60 && flg_o[7] == 1'b0 && flg_o[4] == 1'b0);
    if (op_i == 3'd5 && b_i[2:0] == 3'd0)
      assert_rot_zero_R6: assert (res_o == a_i);
    if (op_i == 3'd7)
      assert_shr_fill_R8: assert (res_o[7] == 1'b0 && flg_o[7] == a_i[0]);
  end
endmodule

bind alu8 alu8_chk u_alu8_chk (
  .a_i(a_i), .b_i(b_i), .op_i(op_i),
  .res_o(res_o), .flg_o(flg_o), .flg_we_o(flg_we_o)
);

// File: tb/test_alu8.sv
module test_alu8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] a, b;
  logic [2:0] op;
  logic [7:0] res, flg, flg_we;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  alu8 i_alu8 (.a_i(a), .b_i(b), .op_i(op), .res_o(res), .flg_o(flg), .flg_we_o(flg_we));

  function automatic string res_tag(int o);
    case (o)
      0: return "R1"; 1: return "R2"; 2, 3, 4: return "R5";
      5: return "R6"; 6: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: op=%0d a=%02h b=%02h actual=%02h expected=%02h",
               tag, what, op, a, b, act, exp);
    end
  endtask

  task automatic run_vec(int o, int x, int y);
    int r, c, v, sx, sy, st, n, en;
    bit full;
    @(posedge clk);
    op = 3'(o); a = 8'(x); b = 8'(y);
    @(negedge clk);
    sx = (x >= 128) ? x - 256 : x;
    sy = (y >= 128) ? y - 256 : y;
    c = 0; v = 0; st = 0;
    case (o)
      0: begin r = (x + y) % 256; c = (x + y) / 256; st = sx + sy; v = (st < -128 || st > 127); end
      1: begin r = (x - y + 256) % 256; c = (x >= y); st = sx - sy; v = (st < -128 || st > 127); end
      2: r = x & y;
      3: r = x | y;
      4: r = x ^ y;
      5: begin n = y % 8; r = ((x >> n) | (x << (8 - n))) % 256; end
      6: begin r = (x * 2) % 256; c = x / 128; v = ((x / 128) % 2) != ((x / 64) % 2); end
      default: begin r = x / 2; c = x % 2; v = x / 128; end
    endcase
    full = (o == 0 || o == 1 || o == 6 || o == 7);
    en   = full ? 8'hF0 : 8'h60;
    check(res_tag(o), "result", int'(res), r);
    check("R10", "flag enables", int'(flg_we), en);
    check(o == 1 ? "R2" : res_tag(o), "carry", int'(flg[7]), full ? c : 0);
    check(full && o < 2 ? "R3" : res_tag(o), "overflow", int'(flg[4]), full ? v : 0);
    check("R4", "zero", int'(flg[6]), r == 0);
    check("R4", "sign", int'(flg[5]), r / 128);
    check("R9", "unused bits", int'({flg[3:0], flg_we[3:0]}), 0);
  endtask

  initial begin
    int vals[16] = '{0, 1, 2, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF,
                     8'h55, 8'hAA, 8'h40, 8'h0F, 8'h08, 8'h10, 8'h3C, 8'hC3};
    op = 3'd0; a = 8'd0; b = 8'd0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9", "idle flag layout", int'({flg[3:0], flg_we[3:0]}), 0);
    check("R10", "idle enables", int'(flg_we), 8'hF0);
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          run_vec(o, vals[i], vals[j]);
    for (int k = 0; k < 32; k++) run_vec(5, 8'hB4, k * 8 + k % 8);
    for (int k = 0; k < 4; k++) begin
      run_vec(6, 8'h96, k * 85);
      run_vec(7, 8'h69, k * 85);
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected=<150000 cycles", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule